// File: doc/BRIEF.md
# Minicomputer Front Panel Controller

This block connects the switches and pushbuttons of a 12-bit minicomputer console to a small processor state. That state is a program counter, a memory address register, a memory data register, and an accumulator with a link bit. Each pushbutton passes through a two-stage synchroniser and a counter-based debouncer. A panel action fires once per press, on the debounced rising edge. A deposit writes one word to an external memory port through a short sequence of states. The twelve value LEDs show one of the four registers. Four one-hot indicator LEDs mark which register is shown.

The command state machine has three states:

| State | Role | Exit |
|-------|------|------|
| `ST_IDLE` | Accepts step, load-PC, load-accumulator and deposit presses. | Goes to `ST_WRITE` on a deposit press while halted. |
| `ST_WRITE` | Asserts the memory write strobe for one cycle. | Goes to `ST_BUMP`. |
| `ST_BUMP` | Advances the program counter. | Returns to `ST_IDLE`. |

A clear press from any state returns the machine to `ST_IDLE`. The display selector is a second four-state machine, `SRC_PC`, `SRC_MA`, `SRC_MD` and `SRC_AC`. Each display press moves it to the next state in that order, and from `SRC_AC` it wraps to `SRC_PC`. A clear press returns it to `SRC_PC`. The RUN LED follows the synchronised run/halt switch.

Top module: `fpanel_ctrl`

## Requirements
- R1: After `rst_n` is released, PC, MA, MD, AC and link are all zero, `led_src` is 4'b0001 (PC shown) and `led_val` is 0.
- R2: The `led_src` bits are bit0=PC, bit1=MA, bit2=MD, bit3=AC. Each display press advances PC→MA→MD→AC→PC, and `led_val` shows the selected register.
- R3: Exactly one bit of `led_src` is set at all times after reset.
- R4: A step press while halted increments PC by one modulo 4096, so 7777 octal becomes 0000.
- R5: A load-PC press while halted copies `sw_val` into PC.
- R6: A deposit press while halted does four things. It sets MA to PC and MD to `sw_val`. It raises `mem_we` for exactly one cycle, with `mem_addr` equal to the old PC and `mem_wdata` equal to `sw_val`. It then increments PC.
- R7: A load-accumulator press while halted copies `sw_val` into AC and `sw_link` into the link bit, and `led_link` shows the link bit.
- R8: A clear press sets PC, MA, MD, AC and link to zero and selects PC for display, whatever the run switch.
- R9: `led_run` follows `sw_run`, two clock cycles late.
- R10: While the synchronised run switch is 1, step, load-PC, deposit and load-accumulator presses change no register and issue no memory write. Display and clear presses still act.
- R11: A button held for fewer than `DEB_CYCLES` consecutive cycles has no effect. A press held longer acts exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_val | input | DATA_W | Value switches (four octal digits) |
| sw_link | input | 1 | Link switch |
| sw_run | input | 1 | Run/halt switch, 1 = run |
| pb_step | input | 1 | Step pushbutton, raw |
| pb_ldpc | input | 1 | Load-PC pushbutton, raw |
| pb_dep | input | 1 | Deposit pushbutton, raw |
| pb_lda | input | 1 | Load-accumulator pushbutton, raw |
| pb_disp | input | 1 | Display-select pushbutton, raw |
| pb_clear | input | 1 | Processor clear pushbutton, raw |
| led_val | output | DATA_W | Value LEDs |
| led_src | output | 4 | One-hot source indicator LEDs |
| led_link | output | 1 | Link LED |
| led_run | output | 1 | RUN LED |
| mem_addr | output | DATA_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Single-cycle memory write strobe |

## Verification
The assertions assume three things about the inputs:
- The value and link switches are static from a press until its action completes. For this reason they are not synchronised.
- Presses are separated by at least a debounce window, so a new deposit never arrives mid-sequence.
- The run switch changes only while no button is held.

The bench keeps to these assumptions. It changes switches only between presses, and it holds and releases every button for longer than the debounce window. The one exception is the deliberate short glitch that tests R11.

// File: rtl/fpanel_pkg.sv
package fpanel_pkg;

    localparam int NBTN      = 6;
    localparam int BTN_STEP  = 0;
    localparam int BTN_LDPC  = 1;
    localparam int BTN_DEP   = 2;
    localparam int BTN_LDA   = 3;
    localparam int BTN_DISP  = 4;
    localparam int BTN_CLEAR = 5;

    typedef enum logic [1:0] {
        SRC_PC = 2'd0,
        SRC_MA = 2'd1,
        SRC_MD = 2'd2,
        SRC_AC = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_BUMP  = 2'd2
    } pst_e;

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
    parameter int N_BTN      = 6,
    parameter int DEB_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BTN-1:0] raw_i,
    output logic [N_BTN-1:0] press_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    for (genvar b = 0; b < N_BTN; b++) begin : g_btn
        logic          s1, s2, stable, pulse;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1     <= 1'b0;
                s2     <= 1'b0;
                stable <= 1'b0;
                pulse  <= 1'b0;
                cnt    <= '0;
            end else begin
                s1    <= raw_i[b];
                s2    <= s1;
                pulse <= 1'b0;
                if (s2 == stable) begin
                    cnt <= '0;
                end else if (cnt == CNT_LAST) begin
                    stable <= s2;
                    cnt    <= '0;
                    pulse  <= s2;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign press_o[b] = pulse;

        // R11
        press_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse |=> !pulse);
    end

endmodule

// File: rtl/panel_fsm.sv
module panel_fsm
    import fpanel_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              ldpc_i,
    input  logic              dep_i,
    input  logic              lda_i,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [DATA_W-1:0] sw_val_i,
    input  logic              sw_link_i,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] ma_o,
    output logic [DATA_W-1:0] md_o,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o,
    output logic              mem_we_o
);
    pst_e state, nxt;
    logic [DATA_W-1:0] pc, ma, md, ac;
    logic              link;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!clr_i && dep_i && !run_i) nxt = ST_WRITE;
            ST_WRITE: nxt = clr_i ? ST_IDLE : ST_BUMP;
            ST_BUMP:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc   <= '0;
            ma   <= '0;
            md   <= '0;
            ac   <= '0;
            link <= 1'b0;
        end else if (clr_i) begin
            pc   <= '0;
            ma   <= '0;
            md   <= '0;
            ac   <= '0;
            link <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!run_i) begin
                        if (step_i) begin
                            pc <= pc + 1'b1;
                        end else if (ldpc_i) begin
                            pc <= sw_val_i;
                        end else if (dep_i) begin
                            ma <= pc;
                            md <= sw_val_i;
                        end else if (lda_i) begin
                            ac   <= sw_val_i;
                            link <= sw_link_i;
                        end
                    end
                end
                ST_WRITE: ;
                ST_BUMP:  pc <= pc + 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        mem_we_o = (state == ST_WRITE);
        pc_o     = pc;
        ma_o     = ma;
        md_o     = md;
        ac_o     = ac;
        link_o   = link;
    end

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && step_i && !run_i && !clr_i) |=> pc == $past(pc) + 1'b1);

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pc == '0 && ac == '0 && !link && ma == '0));

    // R10
    run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i && state == ST_IDLE) |=> ($stable(ac) && $stable(link) && $stable(pc)));

endmodule

// File: rtl/disp_sel.sv
module disp_sel
    import fpanel_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] ma_i,
    input  logic [DATA_W-1:0] md_i,
    input  logic [DATA_W-1:0] ac_i,
    output logic [DATA_W-1:0] led_val_o,
    output logic [3:0]        led_src_o
);
    src_e sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel <= SRC_PC;
        else if (clr_i)  sel <= SRC_PC;
        else if (disp_i) begin
            unique case (sel)
                SRC_PC:  sel <= SRC_MA;
                SRC_MA:  sel <= SRC_MD;
                SRC_MD:  sel <= SRC_AC;
                SRC_AC:  sel <= SRC_PC;
                default: sel <= SRC_PC;
            endcase
        end
    end

    always_comb begin
        led_src_o = 4'b0001 << sel;
        unique case (sel)
            SRC_PC:  led_val_o = pc_i;
            SRC_MA:  led_val_o = ma_i;
            SRC_MD:  led_val_o = md_i;
            SRC_AC:  led_val_o = ac_i;
            default: led_val_o = pc_i;
        endcase
    end

    // R3
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(led_src_o) == 1);

    // R2
    src_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_i && !clr_i) |=> sel == 2'($past(sel) + 2'd1));

endmodule

// File: rtl/fpanel_ctrl.sv
module fpanel_ctrl
    import fpanel_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int DEB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sw_val,
    input  logic              sw_link,
    input  logic              sw_run,
    input  logic              pb_step,
    input  logic              pb_ldpc,
    input  logic              pb_dep,
    input  logic              pb_lda,
    input  logic              pb_disp,
    input  logic              pb_clear,
    output logic [DATA_W-1:0] led_val,
    output logic [3:0]        led_src,
    output logic              led_link,
    output logic              led_run,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    logic [NBTN-1:0]   raw, press;
    logic              run_s1, run_s2;
    logic [DATA_W-1:0] pc, ma, md, ac;
    logic              link;

    always_comb begin
        raw            = '0;
        raw[BTN_STEP]  = pb_step;
        raw[BTN_LDPC]  = pb_ldpc;
        raw[BTN_DEP]   = pb_dep;
        raw[BTN_LDA]   = pb_lda;
        raw[BTN_DISP]  = pb_disp;
        raw[BTN_CLEAR] = pb_clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_s1 <= 1'b0;
            run_s2 <= 1'b0;
        end else begin
            run_s1 <= sw_run;
            run_s2 <= run_s1;
        end
    end

    btn_conditioner #(.N_BTN(NBTN), .DEB_CYCLES(DEB_CYCLES)) u_btn (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .press_o(press)
    );

    panel_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .step_i(press[BTN_STEP]), .ldpc_i(press[BTN_LDPC]),
        .dep_i(press[BTN_DEP]), .lda_i(press[BTN_LDA]),
        .clr_i(press[BTN_CLEAR]), .run_i(run_s2),
        .sw_val_i(sw_val), .sw_link_i(sw_link),
        .pc_o(pc), .ma_o(ma), .md_o(md), .ac_o(ac), .link_o(link),
        .mem_we_o(mem_we)
    );

    disp_sel #(.DATA_W(DATA_W)) u_disp (
        .clk(clk), .rst_n(rst_n),
        .disp_i(press[BTN_DISP]), .clr_i(press[BTN_CLEAR]),
        .pc_i(pc), .ma_i(ma), .md_i(md), .ac_i(ac),
        .led_val_o(led_val), .led_src_o(led_src)
    );

    assign led_link  = link;
    assign led_run   = run_s2;
    assign mem_addr  = ma;
    assign mem_wdata = md;

    // R9
    run_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_s1) |-> led_run);

endmodule

// File: tb/fpanel_ctrl_bench.sv
`timescale 1ns/1ps
module fpanel_ctrl_bench;
    localparam int W   = 12;
    localparam int DEB = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sw_val = '0;
    logic         sw_link = 1'b0, sw_run = 1'b0;
    logic [5:0]   btn = '0;
    logic [W-1:0] led_val, mem_addr, mem_wdata;
    logic [3:0]   led_src;
    logic         led_link, led_run, mem_we;

    int n_chk = 0, n_fail = 0, we_cnt = 0;
    logic [W-1:0] mem [0:255];
    logic [W-1:0] last_addr, last_data;

    always #2.5 clk = ~clk;

    fpanel_ctrl #(.DATA_W(W), .DEB_CYCLES(DEB)) u_fpanel_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_val(sw_val), .sw_link(sw_link), .sw_run(sw_run),
        .pb_step(btn[0]), .pb_ldpc(btn[1]), .pb_dep(btn[2]), .pb_lda(btn[3]),
        .pb_disp(btn[4]), .pb_clear(btn[5]),
        .led_val(led_val), .led_src(led_src), .led_link(led_link), .led_run(led_run),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    always @(posedge clk) if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        last_addr <= mem_addr;
        last_data <= mem_wdata;
        we_cnt <= we_cnt + 1;
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%o expected=%o", req, act, exp);
        end
    endtask

    task automatic press(int b, int hold = DEB + 8);
        @(negedge clk) btn[b] = 1'b1;
        repeat (hold) @(negedge clk);
        btn[b] = 1'b0;
        repeat (DEB + 8) @(negedge clk);
    endtask

    // idx 0=PC 1=MA 2=MD 3=AC
    task automatic show(int idx);
        for (int i = 0; i < 4; i++)
            if (led_src != (4'b0001 << idx)) press(4);
    endtask

    task automatic t_reset();
        check("R1 led_src", {8'h0, led_src}, 12'd1);
        check("R1 PC", led_val, 0);
        show(1); check("R1 MA", led_val, 0);
        show(2); check("R1 MD", led_val, 0);
        show(3); check("R1 AC", led_val, 0);
        check("R1 link", {11'h0, led_link}, 0);
        show(0);
    endtask

    task automatic t_display();
        logic [3:0] exp_seq [0:4] = '{4'b0010, 4'b0100, 4'b1000, 4'b0001, 4'b0010};
        for (int i = 0; i < 5; i++) begin
            press(4);
            check("R2 order", {8'h0, led_src}, {8'h0, exp_seq[i]});
            check("R3 onehot", 12'($countones(led_src)), 1);
        end
        show(0);
    endtask

    task automatic t_ldpc_step();
        sw_val = 12'o0005; press(1);
        check("R5 ldpc", led_val, 12'o0005);
        press(0);
        check("R4 step", led_val, 12'o0006);
        sw_val = 12'o7777; press(1); press(0);
        check("R4 wrap", led_val, 12'o0000);
        sw_val = 12'o0005; press(1);
    endtask

    task automatic t_deposit();
        int w0 = we_cnt;
        sw_val = 12'o0123; press(2);
        check("R6 one strobe", 12'(we_cnt - w0), 1);
        check("R6 addr", last_addr, 12'o0005);
        check("R6 data", last_data, 12'o0123);
        check("R6 mem", mem[5], 12'o0123);
        check("R6 pc inc", led_val, 12'o0006);
        sw_val = 12'o0321; press(2);
        check("R6 next word", mem[6], 12'o0321);
        show(1); check("R6 MA", led_val, 12'o0006);
        show(2); check("R6 MD", led_val, 12'o0321);
        show(0); check("R6 pc", led_val, 12'o0007);
    endtask

    task automatic t_lda();
        sw_val = 12'o0456; sw_link = 1'b1; press(3);
        show(3); check("R7 AC", led_val, 12'o0456);
        check("R7 link", {11'h0, led_link}, 1);
        show(0);
    endtask

    task automatic t_run_lock();
        int w0 = we_cnt;
        sw_run = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 run led", {11'h0, led_run}, 1);
        sw_val = 12'o1111; sw_link = 1'b0;
        press(0); press(1); press(2); press(3);
        check("R10 pc", led_val, 12'o0007);
        check("R10 no write", 12'(we_cnt - w0), 0);
        show(3); check("R10 ac", led_val, 12'o0456);
        check("R10 link", {11'h0, led_link}, 1);
        check("R10 disp works", {8'h0, led_src}, 12'b1000);
        show(0);
        sw_run = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 halt led", {11'h0, led_run}, 0);
    endtask

    task automatic t_glitch();
        press(0, 3);
        check("R11 glitch", led_val, 12'o0007);
        press(0, 3 * DEB);
        check("R11 once", led_val, 12'o0010);
    endtask

    task automatic t_clear();
        show(2);
        sw_run = 1'b1; repeat (4) @(negedge clk);
        press(5);
        check("R8 sel", {8'h0, led_src}, 1);
        check("R8 pc", led_val, 0);
        check("R8 link", {11'h0, led_link}, 0);
        show(1); check("R8 ma", led_val, 0);
        show(2); check("R8 md", led_val, 0);
        show(3); check("R8 ac", led_val, 0);
        sw_run = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_display();
        t_ldpc_step();
        t_deposit();
        t_lda();
        t_run_lock();
        t_glitch();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule